// File: doc/BRIEF.md
# Four-Wire Control Port Slave with Mode Entry

This block is the four-wire serial slave through which a host reaches a byte-wide register file. It samples a select line, a serial clock and a data input with the system clock, and it drives a serial data output together with an output-enable for the pad. After reset the port is dormant, because the chip's default control path is a two-wire bus. The port takes over for good once it has seen three complete low pulses on the select line. A mode output tells the two-wire controller which path owns the registers.

Each transaction runs while select is low. It opens with a header byte whose least significant bit is the direction flag. Two bytes of register subaddress follow, high byte first. After them come one or more data bytes. On a write, each finished data byte produces one write strobe. On a read, the addressed register is shifted out on the data output. In both cases the subaddress steps by one after every data byte, so one selection can cover a run of consecutive registers. If select rises in the middle of a byte, the partial byte is dropped.

Top module: `spi_ctl_slave`

## Requirements
- R1: After reset, `twowire_mode` is 1, `sdo_oe` is 0 and `reg_we` is 0.
- R2: `twowire_mode` falls only after the third completed low pulse (low then high) on `sel_n`. After two pulses it is still 1. Once it is 0 it stays 0 until reset.
- R3: While `twowire_mode` is 1, serial clocks and data inside a select pulse have no effect: no `reg_we` and no `sdo_oe`.
- R4: Input bits are taken on rising `sclk`, MSB first. In header byte 0, bit 0 selects the direction (1 read, 0 write). Bytes 1 and 2 form the 16-bit subaddress, high byte first.
- R5: When a write data byte completes, `reg_we` pulses for exactly one clock, with `reg_addr` set to the current subaddress and `reg_wdata` set to the byte.
- R6: On a read, the addressed register is driven on `sdo` MSB first. Each bit changes after a falling `sclk`, so it is valid at the next rising edge. `sdo_oe` goes high at the first falling edge after the subaddress.
- R7: `sdo_oe` is 0 during a write transaction and returns to 0 once `sel_n` has gone high after a read.
- R8: With `sel_n` held low, the subaddress steps by one after each data byte, for both reads and writes.
- R9: If `sel_n` rises before a byte has all 8 bits, that byte causes no write and the next transaction starts cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Select/latch line, low during a transaction |
| sclk | input | 1 | Serial clock, idle high |
| mosi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Pad enable for `sdo`; low means high impedance |
| twowire_mode | output | 1 | 1 while the two-wire bus owns the registers |
| reg_addr | output | 16 | Register subaddress |
| reg_wdata | output | 8 | Write data to the register file |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data from the register file at `reg_addr` |

## Verification
The hardest case to reach is activity during mode entry. The pulses that count toward entry are also full-looking transactions, so they must leave no trace. The stimulus makes the first counted pulse a complete write frame and the second a complete read frame. It then confirms that no strobe appeared, that the output enable stayed low, and that the register later reads back unchanged. Aborts are provoked by raising select after five data bits, and also inside the subaddress, before a readback and a fresh write to the same location.

// File: rtl/spi_ctl_slave.sv
`timescale 1ns/1ps
module spi_ctl_slave #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter int ENTRY_PULSES = 3,
  parameter int SUB_BYTES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              mosi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              twowire_mode,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int CNT_W  = $clog2(ENTRY_PULSES + 1);
  localparam int HDR    = 1 + SUB_BYTES;
  localparam int BYTE_W = $clog2(HDR + 1);

  logic [2:0]        sel_q, clk_q;
  logic [1:0]        din_q;
  logic              spi_mode, rd_flag, step;
  logic [CNT_W-1:0]  pulses;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] byte_cnt;
  logic [DATA_W-2:0] in_sr;
  logic [DATA_W-1:0] out_sr;

  wire sel_rise = sel_q[1] & ~sel_q[2];
  wire sel_fall = ~sel_q[1] & sel_q[2];
  wire sck_rise = clk_q[1] & ~clk_q[2];
  wire sck_fall = ~clk_q[1] & clk_q[2];
  wire din      = din_q[1];
  wire [DATA_W-1:0] byte_in = {in_sr, din};
  wire last_bit = (bit_cnt == BIT_W'(DATA_W - 1));

  assign twowire_mode = ~spi_mode;
  assign sdo          = sdo_oe & out_sr[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '1;
      clk_q     <= '1;
      din_q     <= '0;
      spi_mode  <= 1'b0;
      pulses    <= '0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      rd_flag   <= 1'b0;
      step      <= 1'b0;
      in_sr     <= '0;
      out_sr    <= '0;
      sdo_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      sel_q  <= {sel_q[1:0], sel_n};
      clk_q  <= {clk_q[1:0], sclk};
      din_q  <= {din_q[0], mosi};
      reg_we <= 1'b0;
      step   <= 1'b0;
      if (step) reg_addr <= reg_addr + 1'b1;

      if (!spi_mode) begin
        if (sel_rise) begin
          if (pulses == CNT_W'(ENTRY_PULSES - 1)) spi_mode <= 1'b1;
          else pulses <= pulses + 1'b1;
        end
      end else if (sel_rise || sel_fall) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        rd_flag  <= 1'b0;
        sdo_oe   <= 1'b0;
      end else if (!sel_q[1]) begin
        if (sck_rise) begin
          in_sr   <= {in_sr[DATA_W-3:0], din};
          bit_cnt <= bit_cnt + 1'b1;
          if (last_bit) begin
            if (byte_cnt != BYTE_W'(HDR)) byte_cnt <= byte_cnt + 1'b1;
            if (byte_cnt == '0)
              rd_flag <= din;
            else if (byte_cnt < BYTE_W'(HDR))
              reg_addr <= {reg_addr[ADDR_W-DATA_W-1:0], byte_in};
            else begin
              step <= 1'b1;
              if (!rd_flag) begin
                reg_we    <= 1'b1;
                reg_wdata <= byte_in;
              end
            end
          end
        end else if (sck_fall && rd_flag && byte_cnt == BYTE_W'(HDR)) begin
          if (bit_cnt == '0) begin
            out_sr <= reg_rdata;
            sdo_oe <= 1'b1;
          end else begin
            out_sr <= out_sr << 1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_ctl_slave_chk.sv
`timescale 1ns/1ps
module spi_ctl_slave_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              sdo_oe,
  input logic              twowire_mode,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we
);
  a_r3_no_write_in_twowire: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !twowire_mode);
  a_r2_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !twowire_mode |=> !twowire_mode);
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r8_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == $past(reg_addr) + 1'b1);
  a_r3_oe_needs_spi: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !twowire_mode);
  a_r6_oe_rises_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sel_n);
endmodule

bind spi_ctl_slave spi_ctl_slave_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/spi_ctl_slave_test.sv
`timescale 1ns/1ps
module spi_ctl_slave_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b1, mosi = 1'b0;
  logic sdo, sdo_oe, twowire_mode, reg_we;
  logic [15:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [7:0]  rf [64];
  logic [7:0]  exp_mem [64];
  logic [23:0] wq [$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_ctl_slave uut (.clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .mosi(mosi),
    .sdo(sdo), .sdo_oe(sdo_oe), .twowire_mode(twowire_mode), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

  assign reg_rdata = rf[reg_addr[5:0]];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: each strobe pops the scoreboard (R5, R3, R9)
  always @(posedge clk) begin
    if (rst_n && reg_we) begin
      rf[reg_addr[5:0]] <= reg_wdata;
      if (wq.size() == 0) check(0, "R3/R9 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [23:0] e;
        e = wq.pop_front();
        check({reg_addr, reg_wdata} == e, "R5/R8 write", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic xbyte(input logic [7:0] b, input int nbits, output logic [7:0] got,
                       output logic oe_seen);
    got = 0; oe_seen = 0;
    for (int i = 0; i < nbits; i++) begin
      sclk = 0; mosi = b[7-i];
      #40;
      got[7-i] = sdo; oe_seen |= sdo_oe;
      sclk = 1;
      #40;
    end
  endtask

  task automatic sel_lo(); sel_n = 0; #80; endtask
  task automatic sel_hi(); #40; sel_n = 1; #160; endtask

  task automatic hdr(input bit rd, input logic [15:0] a, output logic oe);
    logic [7:0] g; logic o1, o2, o3;
    xbyte({7'h2A, rd}, 8, g, o1);
    xbyte(a[15:8], 8, g, o2);
    xbyte(a[7:0], 8, g, o3);
    oe = o1 | o2 | o3;
  endtask

  task automatic wr(input logic [15:0] a, input int n, input logic [7:0] seed, input bit track);
    logic [7:0] g; logic o, od;
    sel_lo();
    hdr(0, a, o);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed + 8'(i * 37);
      if (track) begin
        wq.push_back({a + 16'(i), d});
        exp_mem[(a[5:0] + 6'(i))] = d;
      end
      xbyte(d, 8, g, od);
      o |= od;
    end
    sel_hi();
    if (track) check(!o, "R7 oe low on write", o, 0);
  endtask

  task automatic rd(input logic [15:0] a, input int n, input string req);
    logic [7:0] g; logic o;
    sel_lo();
    hdr(1, a, o);
    check(!o, "R7 oe low before data", o, 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_mem[(a[5:0] + 6'(i))];
      xbyte(8'h00, 8, g, o);
      check(g == e, req, g, e);
      check(o, "R6 oe during read", o, 1);
    end
    sel_hi();
    check(!sdo_oe, "R7 oe released", sdo_oe, 0);
  endtask

  initial begin
    logic [7:0] g; logic o;
    for (int i = 0; i < 64; i++) begin rf[i] = 0; exp_mem[i] = 0; end
    #101 rst_n = 1;
    #40;
    check(twowire_mode && !sdo_oe && !reg_we, "R1 reset state",
          {twowire_mode, sdo_oe, reg_we}, 3'b100);
    // pulse 1: full write frame, must be ignored (R3)
    wr(16'h4003, 1, 8'h5A, 0);
    check(twowire_mode, "R2 after one pulse", twowire_mode, 1);
    // pulse 2: full read frame, output must stay disabled (R3)
    sel_lo(); hdr(1, 16'h4003, o); xbyte(8'h00, 8, g, o); sel_hi();
    check(!o, "R3 no oe in two-wire mode", o, 0);
    check(twowire_mode, "R2 after two pulses", twowire_mode, 1);
    sel_lo(); sel_hi();
    check(!twowire_mode, "R2 after three pulses", twowire_mode, 0);
    rd(16'h4003, 1, "R3 earlier write ignored");
    wr(16'h4005, 1, 8'hA5, 1);
    rd(16'h4005, 1, "R4/R6 single read");
    wr(16'h4010, 3, 8'h3C, 1);
    rd(16'h4010, 3, "R8 burst read");
    rd(16'h4011, 2, "R8 burst read offset");
    // R9: abort after 5 data bits
    sel_lo(); hdr(0, 16'h4005, o); xbyte(8'hFF, 5, g, o); sel_hi();
    rd(16'h4005, 1, "R9 aborted data byte");
    // R9: abort inside subaddress, then a clean write
    sel_lo(); xbyte(8'h00, 8, g, o); xbyte(8'h40, 3, g, o); sel_hi();
    wr(16'h4021, 1, 8'hC3, 1);
    rd(16'h4021, 1, "R9 recovery after abort");
    check(!twowire_mode, "R2 mode sticky", twowire_mode, 0);
    #200;
    check(wq.size() == 0, "R5 all writes seen", wq.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule